// File: doc/BRIEF.md
# Configurable Status Output Pin Multiplexer

The block drives three general-purpose digital output pins, each with an output value and an output enable, so that a pad ring can tristate any of them. Every pin owns an 8-bit configuration register. The register holds a selection code, an invert bit and an analog-mode bit. A low selection code routes one bit of a 32-bit internal status vector to the pin. A few higher codes give a constant level, high impedance, or a divided crystal clock.

Pin 1 shares its pad with the serial data output of an SPI slave. While the active-low chip select is low, the pad carries the SPI data and its enable. The programmed function reaches the pad only while chip select is high. During sleep, a pin whose selection code is a low code is forced to a fixed level until the active-low chip-ready signal drops. Codes at or above 0x20 keep working as programmed. After reset, pin 0 carries the crystal clock divided by 192, so it can serve as the clock of a companion controller. The other two pins are released to high impedance.

Top module: `status_pin_mux`

## Requirements
- R1: While `spi_cs_n` is 0, `pin_oe[1]` equals `spi_so_oe` and `pin_o[1]` equals `spi_so`, whatever pin 1 is configured to.
- R2: After reset, pin 0 is enabled and carries the divided clock (code 0x3F, invert 0). Pin 1 (while `spi_cs_n` is 1) and pin 2 have `pin_oe` at 0 (code 0x2E).
- R3: The divided clock starts at 0 after reset and toggles every DIV/2 = 96 clock cycles, which gives a period of 192 cycles and a 50% duty cycle. Its first rise follows the 96th rising edge after reset is released.
- R4: With a selection code below 0x20 and outside the sleep hold, the pin is enabled and drives `stat_vec[code] XOR invert`.
- R5: With a selection code below 0x20, analog mode clear, `sleep_i` = 1 and `chip_rdy_n` = 1, pins 0 and 2 drive the invert bit and pin 1 drives its complement. All three are enabled.
- R6: Once `chip_rdy_n` falls to 0, the forced sleep levels are released and R4 applies again, even while `sleep_i` stays 1.
- R7: Selection codes of 0x20 and above behave the same whether or not the block is in the sleep hold.
- R8: Code 0x2E clears `pin_oe` in every state, including the sleep hold.
- R9: Configuration bit 7 (analog mode; writing 0x80 selects it) clears `pin_oe` and takes precedence over the sleep hold.
- R10: Code 0x2F drives the invert bit as a constant level. Code 0x3F drives the divided clock XOR invert. Any other code from 0x20 to 0x3F clears `pin_oe`.
- R11: A write with `cfg_we` = 1 to `cfg_addr` 0, 1 or 2 loads `cfg_wdata` into that pin's register at the clock edge. The fields are bits [5:0] code, bit 6 invert and bit 7 analog mode. The new register takes effect on the outputs right after that edge. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Pin index of the write (3 is unused) |
| cfg_wdata | input | 8 | Write data: [5:0] code, [6] invert, [7] analog mode |
| stat_vec | input | 32 | Internal status signals selectable by codes 0x00 to 0x1F |
| sleep_i | input | 1 | Chip is in the sleep state |
| chip_rdy_n | input | 1 | Active-low chip-ready indication |
| spi_cs_n | input | 1 | Active-low SPI chip select |
| spi_so | input | 1 | SPI serial data output from the slave |
| spi_so_oe | input | 1 | Output enable of the SPI data output |
| pin_o | output | 3 | Pin output values |
| pin_oe | output | 3 | Pin output enables (0 = high impedance) |

## Verification
Two behaviours can land in the same cycle, and the bench targets both. The first is a configuration write landing on the same edge where sleep or chip-ready changes. The second is pin 1 being forced by the sleep hold while chip select takes the pad for SPI data. Random stimulus produces both: it writes often, mostly with low codes, and flips `sleep_i`, `chip_rdy_n` and `spi_cs_n` on their own each cycle. Every cycle, a bench model picks the winner in a fixed priority order: SPI sharing, then analog mode, then the sleep hold, then the code table. The model then compares each pin's enable and value. Directed steps hold sleep with chip-ready high on all pins, then drop chip-ready. They also mix analog mode and code 0x2E into the hold.

// File: rtl/spm_pkg.sv
package spm_pkg;

   localparam int SEL_W = 6;
   localparam int CFG_W = 8;

   localparam logic [SEL_W-1:0] CODE_HIZ   = 6'h2E;
   localparam logic [SEL_W-1:0] CODE_CONST = 6'h2F;
   localparam logic [SEL_W-1:0] CODE_CLK   = 6'h3F;

   typedef struct packed {
      logic             ana;
      logic             inv;
      logic [SEL_W-1:0] sel;
   } pin_cfg_t;

   function automatic pin_cfg_t rst_cfg(input int idx);
      pin_cfg_t c;
      c.ana = 1'b0;
      c.inv = 1'b0;
      c.sel = (idx == 0) ? CODE_CLK : CODE_HIZ;
      return c;
   endfunction

endpackage

// File: rtl/spm_cfg_bank.sv
module spm_cfg_bank
   import spm_pkg::*;
#(
   parameter int NPINS = 3,
   parameter int AW    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [AW-1:0]        addr,
   input  logic [CFG_W-1:0]     wdata,
   output pin_cfg_t [NPINS-1:0] cfg_o
);

   for (genvar i = 0; i < NPINS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_o[i] <= rst_cfg(i);
         else if (we && addr == AW'(i))
            cfg_o[i] <= pin_cfg_t'(wdata);
      end
   end

endmodule

// File: rtl/spm_clk_div.sv
module spm_clk_div #(
   parameter int DIV = 192
) (
   input  logic clk,
   input  logic rst_n,
   output logic clk_o
);

   localparam int HALF = DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         clk_o <= 1'b0;
      end else if (cnt == CW'(HALF - 1)) begin
         cnt   <= '0;
         clk_o <= ~clk_o;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/spm_pin_sel.sv
module spm_pin_sel
   import spm_pkg::*;
#(
   parameter int STAT_W   = 32,
   parameter bit FORCE_HI = 1'b0
) (
   input  pin_cfg_t          cfg,
   input  logic [STAT_W-1:0] stat,
   input  logic              sleep_hold,
   input  logic              div_clk,
   output logic              val,
   output logic              oe
);

   localparam int IDX_W = $clog2(STAT_W);
   localparam logic [SEL_W-1:0] LOW_LIM = SEL_W'(STAT_W);

   always_comb begin
      val = 1'b0;
      oe  = 1'b0;
      if (cfg.ana) begin
         // analog mode: digital driver released
         oe = 1'b0;
      end else if (cfg.sel < LOW_LIM) begin
         oe  = 1'b1;
         val = sleep_hold ? (FORCE_HI ^ cfg.inv)
                          : (stat[cfg.sel[IDX_W-1:0]] ^ cfg.inv);
      end else begin
         unique case (cfg.sel)
            CODE_CONST: begin oe = 1'b1; val = cfg.inv;           end
            CODE_CLK:   begin oe = 1'b1; val = div_clk ^ cfg.inv; end
            default:    begin oe = 1'b0; val = 1'b0;              end
         endcase
      end
   end

endmodule

// File: rtl/status_pin_mux.sv
module status_pin_mux
   import spm_pkg::*;
#(
   parameter int NPINS    = 3,
   parameter int STAT_W   = 32,
   parameter int DIV      = 192,
   parameter int SPI_PIN  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic [31:0]       stat_vec,
   input  logic              sleep_i,
   input  logic              chip_rdy_n,
   input  logic              spi_cs_n,
   input  logic              spi_so,
   input  logic              spi_so_oe,
   output logic [2:0]        pin_o,
   output logic [2:0]        pin_oe
);

   if (NPINS != 3)               begin : g_bad_np  $error("NPINS must be 3");              end
   if (STAT_W != 32)             begin : g_bad_sw  $error("STAT_W must equal 2**(SEL_W-1)"); end
   if (DIV < 2 || DIV % 2 != 0)  begin : g_bad_div $error("DIV must be even and >= 2");  end
   if (SPI_PIN >= NPINS)         begin : g_bad_sp  $error("SPI_PIN out of range");       end

   pin_cfg_t [NPINS-1:0] cfg_q;
   logic                 div_clk;
   logic                 sleep_hold;
   logic [NPINS-1:0]     prog_val;
   logic [NPINS-1:0]     prog_oe;

   assign sleep_hold = sleep_i & chip_rdy_n;

   spm_cfg_bank #(.NPINS(NPINS), .AW(2)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .cfg_o (cfg_q)
   );

   spm_clk_div #(.DIV(DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clk_o (div_clk)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      spm_pin_sel #(
         .STAT_W   (STAT_W),
         .FORCE_HI (i == SPI_PIN)
      ) u_sel (
         .cfg        (cfg_q[i]),
         .stat       (stat_vec),
         .sleep_hold (sleep_hold),
         .div_clk    (div_clk),
         .val        (prog_val[i]),
         .oe         (prog_oe[i])
      );

      if (i == SPI_PIN) begin : g_shared
         assign pin_o[i]  = spi_cs_n ? prog_val[i] : spi_so;
         assign pin_oe[i] = spi_cs_n ? prog_oe[i]  : spi_so_oe;
      end else begin : g_plain
         assign pin_o[i]  = prog_val[i];
         assign pin_oe[i] = prog_oe[i];
      end
   end

endmodule

// File: rtl/spm_checker.sv
module spm_checker
   import spm_pkg::*;
#(
   parameter int DIV = 192
) (
   input logic           clk,
   input logic           rst_n,
   input pin_cfg_t [2:0] cfg,
   input logic [31:0]    stat_vec,
   input logic           sleep_i,
   input logic           chip_rdy_n,
   input logic           spi_cs_n,
   input logic           spi_so,
   input logic           spi_so_oe,
   input logic           div_q,
   input logic [2:0]     pin_o,
   input logic [2:0]     pin_oe
);

   localparam int HALF = DIV / 2;
   localparam int GW   = $clog2(HALF + 1) + 1;

   logic [GW-1:0] gap;
   logic          div_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap      <= '0;
         div_prev <= 1'b0;
      end else begin
         div_prev <= div_q;
         gap      <= (div_q != div_prev) ? GW'(1) : gap + 1'b1;
      end
   end

   // R1
   spi_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> (pin_oe[1] == spi_so_oe) && (pin_o[1] == spi_so));

   // R3
   clk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q != div_prev) |-> (gap == GW'(HALF)));

   // R3
   clk_gap_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gap <= GW'(HALF));

   // R4
   stat_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_i && !cfg[0].ana && cfg[0].sel < 6'd32)
      |-> pin_oe[0] && (pin_o[0] == (stat_vec[cfg[0].sel[4:0]] ^ cfg[0].inv)));

   // R5
   sleep_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && chip_rdy_n && !cfg[2].ana && cfg[2].sel < 6'd32)
      |-> pin_oe[2] && (pin_o[2] == cfg[2].inv));

   // R5
   sleep_force_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs_n && sleep_i && chip_rdy_n && !cfg[1].ana && cfg[1].sel < 6'd32)
      |-> pin_oe[1] && (pin_o[1] == !cfg[1].inv));

   // R8
   hiz_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[0].sel == CODE_HIZ) |-> !pin_oe[0]);

   // R9
   analog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[2].ana |-> !pin_oe[2]);

endmodule

bind status_pin_mux spm_checker #(.DIV(DIV)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg        (cfg_q),
   .stat_vec   (stat_vec),
   .sleep_i    (sleep_i),
   .chip_rdy_n (chip_rdy_n),
   .spi_cs_n   (spi_cs_n),
   .spi_so     (spi_so),
   .spi_so_oe  (spi_so_oe),
   .div_q      (div_clk),
   .pin_o      (pin_o),
   .pin_oe     (pin_oe)
);

// File: tb/tb_status_pin_mux.sv
`timescale 1ns/1ps
module tb_status_pin_mux;

   localparam int DIV  = 192;
   localparam int HALF = DIV / 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [31:0] stat_vec = '0;
   logic        sleep_i = 1'b0;
   logic        chip_rdy_n = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_so = 1'b0;
   logic        spi_so_oe = 1'b0;
   logic [2:0]  pin_o;
   logic [2:0]  pin_oe;

   int n_cmp = 0;
   int n_bad = 0;
   int edges = 0;
   logic [7:0] shadow [3];
   bit done = 0;

   always #2.5 clk = ~clk;

   status_pin_mux #(.DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .stat_vec(stat_vec), .sleep_i(sleep_i),
      .chip_rdy_n(chip_rdy_n), .spi_cs_n(spi_cs_n), .spi_so(spi_so),
      .spi_so_oe(spi_so_oe), .pin_o(pin_o), .pin_oe(pin_oe)
   );

   // reference register file and edge count (R11, R3)
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edges     <= 0;
         shadow[0] <= 8'h3F;
         shadow[1] <= 8'h2E;
         shadow[2] <= 8'h2E;
      end else begin
         edges <= edges + 1;
         if (cfg_we && cfg_addr != 2'd3) shadow[cfg_addr] <= cfg_wdata;
      end
   end

   function automatic void model(input int p, output logic eoe,
                                 output logic ev, output string tag);
      logic [5:0] code = shadow[p][5:0];
      logic inv = shadow[p][6];
      logic clkref = ((edges / HALF) % 2) != 0;
      eoe = 1'b0; ev = 1'b0;
      if (p == 1 && !spi_cs_n) begin
         eoe = spi_so_oe; ev = spi_so; tag = "R1";
      end else if (shadow[p][7]) begin
         tag = "R9";
      end else if (code < 6'd32) begin
         eoe = 1'b1;
         if (sleep_i && chip_rdy_n) begin
            ev = (p == 1) ? ~inv : inv; tag = "R5";
         end else begin
            ev = stat_vec[code[4:0]] ^ inv; tag = sleep_i ? "R6" : "R4";
         end
      end else if (code == 6'h2E) begin
         tag = "R8";
      end else if (code == 6'h2F) begin
         eoe = 1'b1; ev = inv; tag = sleep_i ? "R7" : "R10";
      end else if (code == 6'h3F) begin
         eoe = 1'b1; ev = clkref ^ inv; tag = (inv == 0) ? "R3" : "R10";
      end else begin
         tag = sleep_i ? "R7" : "R10";
      end
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      for (int p = 0; p < 3; p++) begin
         logic eoe, ev;
         string tag;
         model(p, eoe, ev, tag);
         chk(tag, $sformatf("pin%0d oe", p), 8'(pin_oe[p]), 8'(eoe));
         if (eoe) chk(tag, $sformatf("pin%0d val", p), 8'(pin_o[p]), 8'(ev));
      end
   endtask

   task automatic step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      step();
      cfg_we = 1'b0;
   endtask

   function automatic logic [7:0] rnd_cfg();
      int k = int'($urandom % 8);
      logic [7:0] d;
      case (k)
         0, 1, 2: d = {2'b00, 1'b0, 5'($urandom)};
         3:       d = 8'h2E;
         4:       d = 8'h2F;
         5:       d = 8'h3F;
         6:       d = {2'b00, 6'($urandom)};
         default: d = 8'h80;
      endcase
      if (k != 7) d[6] = 1'($urandom);
      return d;
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R2: reset state, while reset still held
      chk("R2", "reset oe", 8'(pin_oe), 8'b001);
      chk("R2", "reset pin0", 8'(pin_o[0]), 8'd0);
      rst_n = 1'b1;

      // R3: first rise after 96 edges, fall after 192
      for (int c = 1; c <= 2 * HALF + 2; c++) begin
         stat_vec = $urandom;
         step();
         if (c == HALF - 1) chk("R3", "pre-rise", 8'(pin_o[0]), 8'd0);
         if (c == HALF)     chk("R3", "rise",     8'(pin_o[0]), 8'd1);
         if (c == 2*HALF-1) chk("R3", "pre-fall", 8'(pin_o[0]), 8'd1);
         if (c == 2*HALF)   chk("R3", "fall",     8'(pin_o[0]), 8'd0);
      end

      // random phase: writes (incl. address 3, R11) racing sleep / ready / cs changes
      for (int c = 0; c < 4000; c++) begin
         stat_vec   = $urandom;
         sleep_i    = ($urandom % 3) == 0;
         chip_rdy_n = 1'($urandom);
         spi_cs_n   = ($urandom % 4) != 0;
         spi_so     = 1'($urandom);
         spi_so_oe  = 1'($urandom);
         cfg_we     = ($urandom % 4) == 0;
         cfg_addr   = 2'($urandom);
         cfg_wdata  = rnd_cfg();
         step();
      end
      cfg_we = 1'b0;

      // directed: sleep hold then chip-ready release (R5, R6)
      spi_cs_n = 1'b1; sleep_i = 1'b0; chip_rdy_n = 1'b1;
      stat_vec = 32'hFFFF_FFFF;
      wr(2'd0, 8'h05); wr(2'd1, 8'h05); wr(2'd2, 8'h05);
      sleep_i = 1'b1;
      step();
      chk("R5", "forced levels", 8'(pin_o), 8'b010);
      chk("R5", "forced enables", 8'(pin_oe), 8'b111);
      wr(2'd0, 8'h45); wr(2'd1, 8'h45); wr(2'd2, 8'h45);
      chk("R5", "forced inverted", 8'(pin_o), 8'b101);
      chip_rdy_n = 1'b0;
      step();
      chk("R6", "released", 8'(pin_o), 8'b000);
      chip_rdy_n = 1'b1;
      // R9: analog mode overrides the hold; R8: 0x2E in sleep
      wr(2'd0, 8'h80);
      chk("R9", "analog oe", 8'(pin_oe[0]), 8'd0);
      wr(2'd2, 8'h2E);
      chk("R8", "hiz in sleep", 8'(pin_oe[2]), 8'd0);
      // R11: address 3 leaves everything alone
      wr(2'd3, 8'h2F);
      chk("R11", "addr3 ignored", 8'(pin_oe), 8'b010);
      // R1: cs low hands pin1 to SPI during the hold
      spi_cs_n = 1'b0; spi_so = 1'b0; spi_so_oe = 1'b1;
      step();
      chk("R1", "spi data", 8'(pin_o[1]), 8'd0);
      // R10: constant and inverted clock outside sleep
      spi_cs_n = 1'b1; sleep_i = 1'b0;
      wr(2'd1, 8'h6F);
      chk("R10", "const inv", 8'(pin_o[1]), 8'd1);
      wr(2'd2, 8'h7F);
      repeat (HALF + 3) step();

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule